// File: doc/BRIEF.md
# Self-Checking Word-Line Decoder with Protected Word Store

This block turns a memory address into a one-hot word-line vector and selects one word of a small parity-protected register array. The decoder is built as a cascade: the upper and lower address halves are each predecoded, and the final word lines are the AND of one line from each predecoder. Every stage, and also the final vector, is checked while it runs. An XOR taken over each half of a line vector must give two different values, so a missing or doubled activation is caught. An OR over the lines whose index has odd bit parity must equal the parity of the address, so a line that belongs to the wrong address is caught.

The request inputs carry parity of their own. There is one parity bit each for the address, the write data and the control pair. A mask input blocks any write, whatever the request asks. Each stored word holds a parity bit, and that bit is checked on every read. A fault-injection select lets a test corrupt the word lines or a stored word on purpose.

The control is a two-state machine. In state RUN, requests are served normally. The transition "fault detected" is taken on any detected error, and it leads to state SILENT. SILENT is left only by reset. In SILENT the error flag is high, writes have no effect and reads return zero. The read in the cycle where the fault is found already returns zero.

Top module: `sc_word_decoder`

## Requirements
- R1: After reset, `fail_o` is 0, `rd_valid` is 0 and `rd_data` is 0, and every word of the store reads as 0.
- R2: A request with `req_valid`=1 and `req_we`=0 puts the addressed word on `rd_data` with `rd_valid`=1 after the next rising clock edge. A write with `req_we`=1 stores `req_wdata` at `req_addr` at that edge.
- R3: If the selected final word line is forced to zero (`inj_sel`=1), `fail_o` rises after that edge and the read returns 0.
- R4: If an extra word line, the one at index address XOR 1, is also driven (`inj_sel`=2), the block flags the error in the same way as in R3.
- R5: If the selected line and its neighbour at address XOR 1 are swapped (`inj_sel`=3), the wrong-line error is flagged in the same way as in R3.
- R6: If `req_addr_par` differs from the XOR of the bits of `req_addr` on a valid request, the error is flagged.
- R7: On a write, if `req_wdata_par` differs from the XOR of the bits of `req_wdata`, the error is flagged.
- R8: If `req_ctl_par` differs from NOT(`req_valid` XOR `req_we`) on a valid request, the error is flagged. The control pair is kept at odd parity.
- R9: A write with `inj_sel`=4 stores data bit 0 inverted, with no error at the time of the write. A later read of that word flags the error and returns 0.
- R10: While `wr_mask`=1, a write request leaves the store unchanged and raises no error.
- R11: `fail_o` is sticky until reset. While it is high, reads return 0 with `rd_valid`=1 and writes have no effect.
- R12: A fault inside a predecoder stage (`inj_sel`=5 drops the selected upper predecode line) is flagged by that stage's own check, and `fail_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_ctl_par | input | 1 | Odd-parity bit over valid and write-enable |
| req_addr | input | ADDR_W | Word address |
| req_addr_par | input | 1 | XOR of the address bits |
| req_wdata | input | DATA_W | Write data |
| req_wdata_par | input | 1 | XOR of the write data bits |
| wr_mask | input | 1 | 1 blocks every write |
| inj_sel | input | 3 | Fault injection: 0 none, 1 drop line, 2 extra line, 3 swap pair, 4 flip stored bit 0, 5 drop upper predecode line |
| rd_data | output | DATA_W | Read data, zero when a fault is found or the block is silent |
| rd_valid | output | 1 | Read data valid |
| fail_o | output | 1 | Sticky fail-silent error flag |

## Verification
A wrong word-line vector or a corrupt stored word shows up at the ports at the first rising edge after the faulty access. At that edge `fail_o` goes high and the read data of that access comes back as zero, so no bad value ever leaves the block. Each fault class is injected on its own after a fresh reset. This shows that each check detects its fault by itself, and that the fault is seen in that same cycle rather than at a later access. The mask is checked by reading the word back later, and that read must return the old value.

// File: rtl/sc_dec_pkg.sv
`timescale 1ns/1ps
package sc_dec_pkg;
    typedef enum logic [2:0] {
        INJ_NONE   = 3'd0,
        INJ_DROP   = 3'd1,
        INJ_EXTRA  = 3'd2,
        INJ_SWAP   = 3'd3,
        INJ_FLIP   = 3'd4,
        INJ_STAGE  = 3'd5
    } inj_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_SILENT = 1'b1
    } mode_e;
endpackage

// File: rtl/wl_check.sv
`timescale 1ns/1ps
module wl_check #(
    parameter int IDX_W = 2,
    localparam int N    = 1 << IDX_W
) (
    input  logic [N-1:0] lines,
    input  logic         exp_par,
    output logic         bad_count,
    output logic         bad_select
);
    function automatic logic [N-1:0] odd_mask();
        logic [N-1:0] m;
        for (int i = 0; i < N; i++) begin
            m[i] = ^(i[IDX_W-1:0]);
        end
        return m;
    endfunction

    localparam logic [N-1:0] ODD_MASK = odd_mask();

    logic lo_x, hi_x, rederived;

    always_comb begin
        lo_x       = ^lines[N/2-1:0];
        hi_x       = ^lines[N-1:N/2];
        bad_count  = (lo_x == hi_x);
        rederived  = |(lines & ODD_MASK);
        bad_select = (rederived != exp_par);
    end

    always_comb begin
        if ($countones(lines) == 0) begin
            a_r3_none_flagged: assert (bad_count);
        end
        if ($countones(lines) == 2) begin
            a_r4_pair_flagged: assert (bad_count);
        end
    end
endmodule

// File: rtl/dec_stage.sv
`timescale 1ns/1ps
module dec_stage #(
    parameter int IN_W = 2,
    localparam int N   = 1 << IN_W
) (
    input  logic [IN_W-1:0] addr,
    input  logic            drop,
    output logic [N-1:0]    lines,
    output logic            fault
);
    logic bad_count, bad_select;

    always_comb begin
        lines       = '0;
        lines[addr] = ~drop;
    end

    wl_check #(.IDX_W(IN_W)) u_chk (
        .lines      (lines),
        .exp_par    (^addr),
        .bad_count  (bad_count),
        .bad_select (bad_select)
    );

    assign fault = bad_count | bad_select;
endmodule

// File: rtl/sc_word_decoder.sv
`timescale 1ns/1ps
module sc_word_decoder
    import sc_dec_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic              req_ctl_par,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_addr_par,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_wdata_par,
    input  logic              wr_mask,
    input  logic [2:0]        inj_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              fail_o
);
    localparam int HI_W  = ADDR_W / 2;
    localparam int LO_W  = ADDR_W - HI_W;
    localparam int WORDS = 1 << ADDR_W;
    localparam int HI_N  = 1 << HI_W;
    localparam int LO_N  = 1 << LO_W;

    mode_e state_q, state_d;

    logic [HI_N-1:0]  hi_lines;
    logic [LO_N-1:0]  lo_lines;
    logic             hi_fault, lo_fault;
    logic [WORDS-1:0] raw_wl, wl;
    logic             fin_count, fin_select;
    logic [DATA_W:0]  store [WORDS];
    logic [DATA_W:0]  rword;
    logic             bus_err, dec_err, store_err, fault_now, wr_en;
    logic [ADDR_W-1:0] nb_addr;
    inj_e             inj;

    assign inj     = inj_e'(inj_sel);
    assign nb_addr = req_addr ^ ADDR_W'(1);

    dec_stage #(.IN_W(HI_W)) u_hi (
        .addr  (req_addr[ADDR_W-1:LO_W]),
        .drop  (inj == INJ_STAGE),
        .lines (hi_lines),
        .fault (hi_fault)
    );

    dec_stage #(.IN_W(LO_W)) u_lo (
        .addr  (req_addr[LO_W-1:0]),
        .drop  (1'b0),
        .lines (lo_lines),
        .fault (lo_fault)
    );

    for (genvar g = 0; g < WORDS; g++) begin : g_wl
        assign raw_wl[g] = hi_lines[g / LO_N] & lo_lines[g % LO_N];
    end

    always_comb begin
        wl = raw_wl;
        unique case (inj)
            INJ_DROP:  wl[req_addr] = 1'b0;
            INJ_EXTRA: wl[nb_addr]  = 1'b1;
            INJ_SWAP: begin
                wl[req_addr] = raw_wl[nb_addr];
                wl[nb_addr]  = raw_wl[req_addr];
            end
            default: ;
        endcase
    end

    wl_check #(.IDX_W(ADDR_W)) u_fin_chk (
        .lines      (wl),
        .exp_par    (^req_addr),
        .bad_count  (fin_count),
        .bad_select (fin_select)
    );

    always_comb begin
        rword = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (wl[i]) rword = rword | store[i];
        end
    end

    always_comb begin
        bus_err   = (req_addr_par != ^req_addr)
                  | (req_ctl_par == (req_valid ^ req_we))
                  | (req_we & (req_wdata_par != ^req_wdata));
        dec_err   = hi_fault | lo_fault | fin_count | fin_select;
        store_err = ~req_we & (^rword);
        fault_now = req_valid & (bus_err | dec_err | store_err);
        wr_en     = req_valid & req_we & ~wr_mask & ~fault_now
                  & (state_q == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (fault_now) state_d = ST_SILENT;
            ST_SILENT: state_d = ST_SILENT;
            default:   state_d = ST_SILENT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            for (int i = 0; i < WORDS; i++) store[i] <= '0;
        end else begin
            rd_valid <= req_valid & ~req_we;
            if (req_valid & ~req_we)
                rd_data <= (fault_now || state_q == ST_SILENT) ? '0 : rword[DATA_W-1:0];
            for (int i = 0; i < WORDS; i++) begin
                if (wr_en && wl[i])
                    store[i] <= {req_wdata_par,
                                 req_wdata ^ {{(DATA_W-1){1'b0}}, inj == INJ_FLIP}};
            end
        end
    end

    assign fail_o = (state_q == ST_SILENT);

    a_r11_sticky_fail: assert property (@(posedge clk) disable iff (rst)
        fail_o |=> fail_o);
    a_r11_silent_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && fail_o) |-> (rd_data == '0));
    a_r2_read_response: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(req_valid && !req_we));
    a_r12_stage_fault: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (hi_fault || lo_fault)) |=> fail_o);
endmodule

// File: tb/tb_sc_word_decoder.sv
`timescale 1ns/1ps
module tb_sc_word_decoder;
    localparam int AW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_we, req_ctl_par, req_addr_par, req_wdata_par, wr_mask;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic [2:0]    inj_sel;
    logic [DW-1:0] rd_data;
    logic          rd_valid, fail_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sc_word_decoder #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk, .rst, .req_valid, .req_we, .req_ctl_par, .req_addr, .req_addr_par,
        .req_wdata, .req_wdata_par, .wr_mask, .inj_sel, .rd_data, .rd_valid, .fail_o
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_we = 0; req_ctl_par = 1; req_addr = '0; req_addr_par = 0;
        req_wdata = '0; req_wdata_par = 0; wr_mask = 0; inj_sel = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst = 1;
        @(posedge clk); @(posedge clk);
        #1 rst = 0;
    endtask

    // bad: bit0 address parity, bit1 data parity, bit2 control parity
    task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic msk, input logic [2:0] inj, input logic [2:0] bad);
        @(negedge clk);
        req_valid     = 1;
        req_we        = we;
        req_ctl_par   = ~(1'b1 ^ we) ^ bad[2];
        req_addr      = a;
        req_addr_par  = (^a) ^ bad[0];
        req_wdata     = d;
        req_wdata_par = (^d) ^ bad[1];
        wr_mask       = msk;
        inj_sel       = inj;
        @(posedge clk);
        #1 idle();
    endtask

    task automatic test_reset();
        do_reset();
        #1;
        check("R1 fail after reset", fail_o, 0);
        check("R1 rd_valid after reset", rd_valid, 0);
        check("R1 rd_data after reset", rd_data, 0);
        access(0, 4'd12, 0, 0, 0, 0);
        check("R1 store cleared", rd_data, 0);
    endtask

    task automatic test_rw();
        do_reset();
        for (int i = 0; i < 16; i++) access(1, i[AW-1:0], DW'(8'h5A ^ (i * 17)), 0, 0, 0);
        for (int i = 0; i < 16; i++) begin
            access(0, i[AW-1:0], 0, 0, 0, 0);
            check("R2 read data", rd_data, DW'(8'h5A ^ (i * 17)));
            check("R2 rd_valid", rd_valid, 1);
        end
        check("R2 no fault on clean traffic", fail_o, 0);
    endtask

    task automatic test_mask();
        do_reset();
        access(1, 4'd7, 8'h11, 0, 0, 0);
        access(1, 4'd7, 8'hFF, 1, 0, 0);
        check("R10 masked write no fault", fail_o, 0);
        access(0, 4'd7, 0, 0, 0, 0);
        check("R10 masked write ignored", rd_data, 8'h11);
    endtask

    task automatic test_inj(input string req, input logic [2:0] inj, input logic [AW-1:0] a);
        do_reset();
        access(1, a, 8'hC3, 0, 0, 0);
        access(0, a, 0, 0, inj, 0);
        check({req, " fault flagged"}, fail_o, 1);
        check({req, " read forced zero"}, rd_data, 0);
    endtask

    task automatic test_bus(input string req, input logic [2:0] bad, input logic we);
        do_reset();
        access(we, 4'd3, 8'h96, 0, 0, bad);
        check({req, " parity error flagged"}, fail_o, 1);
    endtask

    task automatic test_flip();
        do_reset();
        access(1, 4'd9, 8'h40, 0, 3'd4, 0);
        check("R9 no fault at corrupt write", fail_o, 0);
        access(0, 4'd9, 0, 0, 0, 0);
        check("R9 stored flip flagged", fail_o, 1);
        check("R9 read forced zero", rd_data, 0);
    endtask

    task automatic test_sticky();
        do_reset();
        access(1, 4'd5, 8'h77, 0, 0, 0);
        access(0, 4'd2, 0, 0, 3'd1, 0);
        access(1, 4'd5, 8'h22, 0, 0, 0);
        access(0, 4'd5, 0, 0, 0, 0);
        check("R11 fail stays high", fail_o, 1);
        check("R11 silent read zero", rd_data, 0);
        check("R11 silent rd_valid", rd_valid, 1);
        @(negedge clk); rst = 1; @(posedge clk); #1 rst = 0;
        check("R11 reset clears fail", fail_o, 0);
    endtask

    initial begin
        rst = 1;
        idle();
        test_reset();
        test_rw();
        test_mask();
        test_inj("R3 dropped line", 3'd1, 4'd6);
        test_inj("R4 extra line", 3'd2, 4'd6);
        test_inj("R4 extra line odd", 3'd2, 4'd13);
        test_inj("R5 swapped pair", 3'd3, 4'd6);
        test_inj("R5 swapped pair odd", 3'd3, 4'd11);
        test_inj("R12 stage line dropped", 3'd5, 4'd14);
        test_bus("R6 address", 3'b001, 0);
        test_bus("R7 write data", 3'b010, 1);
        test_bus("R8 control", 3'b100, 0);
        test_flip();
        test_sticky();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule